// File: doc/BRIEF.md
# Stereo Polyphase Convolution Sequencer

This block runs the filter arithmetic of a stereo sample rate converter. Each accepted start loads a sample-memory start address, a 26-bit filter phase and a phase step. From those it walks the filter taps: the sample address moves down by one and the phase moves up by the step on every cycle. A single multiply-accumulate unit adds the product of the sample word and the coefficient word on each tap. A pass ends when the phase carries out of its top bit, so the tap count follows the rate ratio rather than a counter.

The left channel is convolved first. The right channel then runs from the same loaded addresses, and the MAC is shared between the two. When the right pass ends, both results are rounded down, saturated to 24 bits and presented together with a one-cycle done pulse.

The read ports are asynchronous. The sample word for `ram_addr_o` and `ch_o`, and the coefficient for `rom_addr_o`, must be valid in the same cycle as the address.

Top module: `fir_conv_seq`

## Requirements
- R1: `start_i` in the idle state is taken at the clock edge. In the next cycle `rd_en_o`=1, `ch_o`=0, `ram_addr_o`=`ram_start_i`, and `rom_addr_o`=`phase_i[25:16]`.
- R2: On each later tap of a pass, `ram_addr_o` is one less than on the previous tap, modulo 256.
- R3: The 26-bit phase grows by the step on every tap. A pass ends on the tap whose addition carries out of bit 25, so it has ceil((2^26 - phase)/step) taps. With step 2^20 and phase 0 that is 64 taps; with step 2^19 it is 128 taps.
- R4: A step of 0, or a step above 2^20, is used as 2^20.
- R5: The left pass (`ch_o`=0) is followed at once by the right pass (`ch_o`=1). The right pass restarts from the loaded address and phase. `rd_en_o` is high for exactly 2N consecutive cycles, where N is the number of taps in one pass.
- R6: A channel result is the sum of signed 24-bit sample × signed 16-bit coefficient products over its pass. The sum is kept in a 40-bit two's-complement accumulator that wraps. It is shifted right arithmetically by 15 and saturated to the range -2^23 to 2^23-1.
- R7: `done_o` is a one-cycle pulse in the cycle after the last right-channel tap. `left_o` and `right_o` take their new values in that same cycle and hold them until the next pulse.
- R8: `start_i`, and changes to `ram_start_i`, `phase_i` and `step_i`, have no effect while a convolution is running, including during its last tap cycle.
- R9: After reset, `rd_en_o`, `done_o`, `left_o` and `right_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a convolution for the next output sample |
| ram_start_i | input | 8 | Sample memory address of the newest tap |
| phase_i | input | 26 | Starting filter phase |
| step_i | input | 21 | Phase step per tap (2^20 = unit ratio) |
| ram_addr_o | output | 8 | Sample memory read address |
| ch_o | output | 1 | Channel being read: 0 left, 1 right |
| rd_en_o | output | 1 | Tap read active |
| ram_data_i | input | 24 | Signed sample word at ram_addr_o / ch_o |
| rom_addr_o | output | 10 | Coefficient read address (phase bits 25:16) |
| coef_i | input | 16 | Signed coefficient at rom_addr_o |
| left_o | output | 24 | Saturated left result |
| right_o | output | 24 | Saturated right result |
| done_o | output | 1 | Results updated this cycle |

## Verification
The bench drives phases that do not divide evenly into the step, and checks tap counts of 64, 128 and 86. A design that stopped on a fixed count, or that took the carry one tap early or late, would miss these counts by one or more. It starts runs near address zero, so that a sample address failing to wrap modulo 256 would read the wrong samples. It feeds steps of zero and above unity, which an unclamped design would hang on or shorten. It fills memory with full-scale words of both signs, and a design that truncated instead of saturating would return wrapped values. It holds `start_i` high through a whole run, including its last tap, so that a sequencer that restarted early would shift every later check.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEFT  = 2'd1,
    ST_RIGHT = 2'd2
  } conv_state_e;
endpackage

// File: rtl/conv_addr_gen.sv
module conv_addr_gen #(
  parameter int RAM_AW  = 8,
  parameter int PHASE_W = 26,
  parameter int STEP_W  = 21,
  parameter int COEF_AW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [RAM_AW-1:0]  ram_start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic [RAM_AW-1:0]  ram_addr_o,
  output logic [COEF_AW-1:0] rom_addr_o,
  output logic               wrap_o
);
  localparam logic [STEP_W-1:0] UNIT_STEP = {1'b1, {(STEP_W-1){1'b0}}};

  logic [RAM_AW-1:0]  ram_base_q, ram_ptr_q;
  logic [PHASE_W-1:0] phase_base_q, rom_ptr_q;
  logic [STEP_W-1:0]  step_q;
  logic [PHASE_W:0]   sum_w;

  assign sum_w      = {1'b0, rom_ptr_q} + {{(PHASE_W+1-STEP_W){1'b0}}, step_q};
  assign wrap_o     = sum_w[PHASE_W];
  assign ram_addr_o = ram_ptr_q;
  assign rom_addr_o = rom_ptr_q[PHASE_W-1 -: COEF_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_base_q   <= '0;
      ram_ptr_q    <= '0;
      phase_base_q <= '0;
      rom_ptr_q    <= '0;
      step_q       <= UNIT_STEP;
    end else if (load_i) begin
      ram_base_q   <= ram_start_i;
      ram_ptr_q    <= ram_start_i;
      phase_base_q <= phase_i;
      rom_ptr_q    <= phase_i;
      step_q       <= step_i;
    end else if (adv_i) begin
      if (wrap_o) begin
        // pass over: next channel restarts from the loaded pointers
        ram_ptr_q <= ram_base_q;
        rom_ptr_q <= phase_base_q;
      end else begin
        ram_ptr_q <= ram_ptr_q - 1'b1;
        rom_ptr_q <= sum_w[PHASE_W-1:0];
      end
    end
  end

  // R2
  ram_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_o && !load_i) |=> (ram_addr_o == $past(ram_addr_o) - 1'b1));

  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_o && !load_i) |=> (ram_ptr_q == ram_base_q && rom_ptr_q == phase_base_q));

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (step_q != '0 && step_q <= UNIT_STEP));
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
  parameter int DATA_W    = 24,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int OUT_SHIFT = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     clr_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [DATA_W-1:0] res_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [DATA_W-1:0] RES_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] RES_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_w;
  logic signed [ACC_W-1:0]  acc_q, acc_d, shifted_w;
  logic [ACC_W-DATA_W:0]    hi_w;

  assign prod_w    = sample_i * coef_i;
  assign acc_d     = acc_q + ACC_W'(prod_w);
  assign shifted_w = acc_d >>> OUT_SHIFT;
  assign hi_w      = shifted_w[ACC_W-1:DATA_W-1];

  always_comb begin
    if (&hi_w || ~|hi_w) res_o = shifted_w[DATA_W-1:0];
    else if (shifted_w[ACC_W-1]) res_o = RES_MIN;
    else res_o = RES_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end
endmodule

// File: rtl/fir_conv_seq.sv
module fir_conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int OUT_SHIFT = 15,
  parameter int RAM_AW    = 8,
  parameter int TAP_LOG2  = 6,
  parameter int FRAC_W    = 20,
  parameter int COEF_AW   = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [RAM_AW-1:0]        ram_start_i,
  input  logic [TAP_LOG2+FRAC_W-1:0] phase_i,
  input  logic [FRAC_W:0]          step_i,
  output logic [RAM_AW-1:0]        ram_addr_o,
  output logic                     ch_o,
  output logic                     rd_en_o,
  input  logic signed [DATA_W-1:0] ram_data_i,
  output logic [COEF_AW-1:0]       rom_addr_o,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic                     done_o
);
  localparam int PHASE_W = TAP_LOG2 + FRAC_W;
  localparam int STEP_W  = FRAC_W + 1;
  localparam logic [STEP_W-1:0] UNIT_STEP = {1'b1, {(STEP_W-1){1'b0}}};

  conv_state_e state_q;
  logic busy_w, load_w, wrap_w;
  logic [STEP_W-1:0] step_eff_w;
  logic signed [DATA_W-1:0] res_w, left_hold_q;

  assign busy_w     = (state_q != ST_IDLE);
  assign load_w     = start_i && !busy_w;
  assign step_eff_w = (step_i == '0 || step_i > UNIT_STEP) ? UNIT_STEP : step_i;
  assign rd_en_o    = busy_w;
  assign ch_o       = (state_q == ST_RIGHT);

  conv_addr_gen #(
    .RAM_AW(RAM_AW), .PHASE_W(PHASE_W), .STEP_W(STEP_W), .COEF_AW(COEF_AW)
  ) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_w), .adv_i(busy_w),
    .ram_start_i(ram_start_i), .phase_i(phase_i), .step_i(step_eff_w),
    .ram_addr_o(ram_addr_o), .rom_addr_o(rom_addr_o), .wrap_o(wrap_w)
  );

  conv_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_SHIFT(OUT_SHIFT)
  ) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy_w),
    .clr_i(load_w || (busy_w && wrap_w)),
    .sample_i(ram_data_i), .coef_i(coef_i), .res_o(res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_LEFT;
        ST_LEFT:  if (wrap_w) begin
          left_hold_q <= res_w;
          state_q     <= ST_RIGHT;
        end
        ST_RIGHT: if (wrap_w) begin
          left_o  <= left_hold_q;
          right_o <= res_w;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o);

  // R5
  ch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_o) |-> $past(rd_en_o));

  // R7
  result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: tb/fir_conv_seq_bench.sv
module fir_conv_seq_bench;
  localparam int UNIT = 1 << 20;
  localparam longint PH_SPAN = 64'd1 << 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0]  ram_start = '0;
  logic [25:0] phase = '0;
  logic [20:0] step = '0;
  logic [7:0]  ram_addr;
  logic        ch, rd_en, done;
  logic signed [23:0] ram_data;
  logic [9:0]  rom_addr;
  logic signed [15:0] coef;
  logic signed [23:0] left, right;

  int ram_l [256];
  int ram_r [256];
  int coef_mem [1024];
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fir_conv_seq u_fir_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ram_start_i(ram_start),
    .phase_i(phase), .step_i(step), .ram_addr_o(ram_addr), .ch_o(ch),
    .rd_en_o(rd_en), .ram_data_i(ram_data), .rom_addr_o(rom_addr),
    .coef_i(coef), .left_o(left), .right_o(right), .done_o(done)
  );

  always_comb begin
    ram_data = ch ? 24'(ram_r[ram_addr]) : 24'(ram_l[ram_addr]);
    coef     = 16'(coef_mem[rom_addr]);
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model
  bit     m_busy = 0, m_pass = 0, m_done = 0;
  int     m_k = 0, m_n = 0;
  longint m_base = 0, m_ph = 0, m_st = 0;
  longint m_left = 0, m_right = 0, m_res_l = 0, m_res_r = 0;

  function automatic longint conv(longint base, longint ph, longint st, bit side);
    longint acc = 0;
    longint sh;
    for (int k = 0; ph + k * st < PH_SPAN; k++) begin
      int a = int'((base - k) & 255);
      int c = int'(((ph + k * st) >> 16) & 1023);
      acc += longint'(side ? ram_r[a] : ram_l[a]) * longint'(coef_mem[c]);
      acc = (acc <<< 24) >>> 24;
    end
    sh = acc >>> 15;
    if (sh > 8388607) sh = 8388607;
    if (sh < -8388608) sh = -8388608;
    return sh;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_right = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_k++;
        if (m_k == m_n) begin
          m_k = 0;
          if (!m_pass) m_pass = 1;
          else begin
            m_busy = 0; m_done = 1; m_left = m_res_l; m_right = m_res_r;
          end
        end
      end else if (start) begin
        m_base = ram_start; m_ph = phase;
        m_st = (step == 0 || step > UNIT) ? UNIT : step;
        m_n = int'((PH_SPAN - m_ph + m_st - 1) / m_st);
        m_res_l = conv(m_base, m_ph, m_st, 0);
        m_res_r = conv(m_base, m_ph, m_st, 1);
        m_busy = 1; m_pass = 0; m_k = 0;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5", "rd_en", rd_en, m_busy);
      if (m_busy) begin
        check("R5", "ch", ch, m_pass);
        if (m_k == 0 && !m_pass) begin
          check("R1", "first ram_addr", ram_addr, m_base);
          check("R1", "first rom_addr", rom_addr, (m_ph >> 16) & 1023);
        end else begin
          check("R2", "ram_addr", ram_addr, (m_base - m_k) & 255);
          check("R3", "rom_addr", rom_addr, ((m_ph + m_k * m_st) >> 16) & 1023);
        end
      end
      check("R7", "done", done, m_done);
      check("R6", "left", left, m_left);
      check("R6", "right", right, m_right);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // hold_start keeps start high through the run (R8)
  task automatic run(input logic [7:0] rs, input logic [25:0] ph, input logic [20:0] st,
                     input bit hold_start, output int rd_cycles);
    @(negedge clk);
    ram_start = rs; phase = ph; step = st; start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    rd_cycles = 0;
    for (int i = 0; i < 20000 && !done; i++) begin
      if (rd_en) rd_cycles++;
      if (hold_start) begin
        ram_start = ram_start + 8'd3; phase = phase + 26'd777; step = 21'd12345;
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int rc;
    for (int i = 0; i < 256; i++) begin
      ram_l[i] = ((i * 1013) % 40001) - 20000;
      ram_r[i] = 15000 - ((i * 677) % 30011);
    end
    for (int i = 0; i < 1024; i++) coef_mem[i] = ((i * 37) % 2001) - 1000;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "rd_en in reset", rd_en, 0);
    check("R9", "done in reset", done, 0);
    check("R9", "left in reset", left, 0);
    check("R9", "right in reset", right, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(8'd100, 26'd0, 21'(UNIT), 0, rc);
    check("R3", "64-tap read cycles", rc, 128);
    run(8'd5, 26'd0, 21'(UNIT / 2), 0, rc);
    check("R3", "128-tap read cycles (addr wrap R2)", rc, 256);
    run(8'd200, 26'd100000, 21'd786432, 0, rc);
    check("R3", "86-tap read cycles", rc, 172);
    run(8'd17, 26'd4000, 21'd0, 0, rc);
    check("R4", "zero step read cycles", rc, 128);
    run(8'd33, 26'd0, 21'h1FFFFF, 0, rc);
    check("R4", "oversize step read cycles", rc, 128);
    run(8'd60, 26'd0, 21'(UNIT), 1, rc);
    check("R8", "held start read cycles", rc, 128);
    check("R8", "held start left", left, conv(60, 0, UNIT, 0));

    for (int i = 0; i < 256; i++) begin
      ram_l[i] = 1 << 22;
      ram_r[i] = -(1 << 22);
    end
    for (int i = 0; i < 1024; i++) coef_mem[i] = 1200;
    run(8'd0, 26'd0, 21'(UNIT), 0, rc);
    check("R6", "positive saturation", left, 8388607);
    check("R6", "negative saturation", right, -8388608);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule